// File: doc/BRIEF.md
# Single-Wire Debug Bit Transceiver

This block is the target-side bit engine of a one-wire background debug link. The line is open-drain with a permanent weak pull-up. An external host starts every bit time with a falling edge, whichever way the data moves. The engine times everything in target clocks, which are the system clock divided by a parameter (8 by default). It measures each delay from the tick on which it detects the host edge.

A command layer starts a transfer with a one-cycle request, choosing the direction and an 8- or 16-bit length.

- **Receive:** the engine samples the line part-way into each bit and shifts the value in most significant bit first.
- **Send:** it holds the line low for a zero. For a one it gives a single target-clock high speedup pulse and then lets the pull-up hold the line.

The engine reports completion with a one-cycle strobe. It abandons the transfer with a timeout strobe when the host stays silent too long.

Top module: `owire_bit_xcvr`

## Requirements
- R1: After reset and while idle, `pin_oe_o`, `pin_do_o`, `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A `start_i` pulse while idle makes `busy_o` 1 on the next cycle. A `start_i` pulse while busy is ignored: it changes neither the direction nor the data of the transfer in progress.
- R3: In receive (`dir_tx_i`=0), each bit is the line level sampled 10 target clocks after the detected host falling edge, high giving 1. Bits are shifted in most significant first.
- R4: `len16_i`=1 selects 16 bits per transfer and `len16_i`=0 selects 8. An 8-bit receive leaves the byte in `rx_data_o[7:0]` with the upper bits 0. An 8-bit send transmits `tx_data_i[7:0]`, most significant bit first.
- R5: In send (`dir_tx_i`=1), a 0 bit drives the line low (`pin_oe_o`=1, `pin_do_o`=0) for exactly 13 target clocks starting at the detected edge, then releases it.
- R6: In send, a 1 bit drives the line high (`pin_oe_o`=1, `pin_do_o`=1) for exactly one target clock, 4 target clocks after the detected edge. Apart from this, `pin_do_o` is never 1.
- R7: The engine never asserts `pin_oe_o` while idle or receiving.
- R8: `done_o` pulses for one cycle when the last bit completes. In that same cycle `busy_o` is 0 and `rx_data_o` already holds the final bit.
- R9: If 512 target clocks pass without a host falling edge during a transfer, `timeout_o` pulses once, `busy_o` falls and no `done_o` is given. It does not fire before 500 target clocks.
- R10: After a timeout, a new transfer starts and completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the target clock is this divided by TICK_DIV |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Level of the debug line (asynchronous) |
| start_i | input | 1 | One-cycle request to begin a transfer |
| dir_tx_i | input | 1 | 1 = send to host, 0 = receive from host |
| len16_i | input | 1 | 1 = 16-bit transfer, 0 = 8-bit transfer |
| tx_data_i | input | 16 | Data to send, captured at start |
| pin_oe_o | output | 1 | Drive enable for the line pad |
| pin_do_o | output | 1 | Value driven when enabled |
| rx_data_o | output | 16 | Received shift register contents |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle strobe: all bits transferred |
| timeout_o | output | 1 | One-cycle strobe: transfer aborted for host silence |

## Verification
The final bit's sample and the completion strobe coincide: on one target-clock tick the last received bit is shifted in, `busy_o` drops and `done_o` rises. The bench records `rx_data_o` and `busy_o` in the exact cycle `done_o` is high. It uses words whose last bit is 1, such as 0x01, so that a register image one cycle late would miss that bit and fail the compare.

A second coincidence is the watchdog limit meeting a host edge. The timeout test judges it from both sides: it sees no strobe before 500 target clocks of silence, and exactly one strobe without a completion once 512 have passed.

// File: rtl/owb_pkg.sv
package owb_pkg;
  typedef enum logic {
    OWB_RX = 1'b0,
    OWB_TX = 1'b1
  } owb_dir_e;
endpackage

// File: rtl/owb_tick_gen.sv
module owb_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(DIV - 2));
      cnt  <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/owb_line_sync.sv
module owb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owb_watchdog.sv
module owb_watchdog #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt <= '0;
    else if (run && tick)  cnt <= cnt + 1'b1;
  end

  assign expire = run && tick && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/owire_bit_xcvr.sv
module owire_bit_xcvr #(
  parameter int TICK_DIV   = 8,
  parameter int SYNC_STG   = 2,
  parameter int WORD_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int TOUT_TICKS = 512,
  parameter int SAMPLE_AT  = 10,
  parameter int PULSE_AT   = 4,
  parameter int RELEASE_AT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_i,
  input  logic              start_i,
  input  logic              dir_tx_i,
  input  logic              len16_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              pin_oe_o,
  output logic              pin_do_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  import owb_pkg::*;

  localparam int PH_W = $clog2(RELEASE_AT + 1);
  localparam int BC_W = $clog2(WORD_W + 1);

  logic              tick, lvl, prev_lvl, expire;
  logic              in_bit, txbit;
  owb_dir_e          dir_q;
  logic              len_q;
  logic [PH_W-1:0]   ph;
  logic [BC_W-1:0]   bits;
  logic [WORD_W-1:0] sh;
  logic              fall, edge_ok, bit_end, last_bit, cur_bit, start_ok;
  logic              oe_want;

  owb_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  owb_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(pin_i), .q(lvl)
  );

  owb_watchdog #(.LIMIT(TOUT_TICKS)) u_wd (
    .clk(clk), .rst(rst), .tick(tick),
    .clear(start_ok || edge_ok), .run(busy_o), .expire(expire)
  );

  // Host edge: previous tick saw high, this tick sees low.
  assign fall     = tick && prev_lvl && !lvl;
  assign edge_ok  = fall && busy_o && !in_bit;
  assign start_ok = start_i && !busy_o;
  assign cur_bit  = len_q ? sh[WORD_W-1] : sh[BYTE_W-1];
  assign last_bit = len_q ? (bits == BC_W'(WORD_W - 1)) : (bits == BC_W'(BYTE_W - 1));
  assign bit_end  = tick && in_bit &&
                    ((dir_q == OWB_TX) ? (ph == PH_W'(RELEASE_AT - 1))
                                       : (ph == PH_W'(SAMPLE_AT - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl  <= 1'b1;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      in_bit    <= 1'b0;
      txbit     <= 1'b0;
      dir_q     <= OWB_RX;
      len_q     <= 1'b0;
      ph        <= '0;
      bits      <= '0;
      sh        <= '0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (tick) prev_lvl <= lvl;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          dir_q  <= owb_dir_e'(dir_tx_i);
          len_q  <= len16_i;
          sh     <= dir_tx_i ? tx_data_i : '0;
          bits   <= '0;
          in_bit <= 1'b0;
        end
      end else if (expire && !edge_ok) begin
        busy_o    <= 1'b0;
        in_bit    <= 1'b0;
        timeout_o <= 1'b1;
      end else if (edge_ok) begin
        in_bit <= 1'b1;
        ph     <= '0;
        txbit  <= cur_bit;
      end else if (bit_end) begin
        in_bit <= 1'b0;
        sh     <= {sh[WORD_W-2:0], (dir_q == OWB_TX) ? 1'b0 : lvl};
        bits   <= bits + 1'b1;
        if (last_bit) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (tick && in_bit) begin
        ph <= ph + 1'b1;
      end
    end
  end

  // Pad control: low for a zero until release, one-tick high pulse for a one.
  assign oe_want = busy_o && in_bit && (dir_q == OWB_TX) &&
                   (txbit ? (ph == PH_W'(PULSE_AT)) : (ph < PH_W'(RELEASE_AT)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe_o <= 1'b0;
      pin_do_o <= 1'b0;
    end else begin
      pin_oe_o <= oe_want;
      pin_do_o <= oe_want && txbit;
    end
  end

  assign rx_data_o = sh;
endmodule

// File: rtl/owire_bit_xcvr_chk.sv
module owire_bit_xcvr_chk #(
  parameter int TICK_DIV = 8
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic busy_o,
  input logic dir_q,
  input logic pin_oe_o,
  input logic pin_do_o,
  input logic done_o,
  input logic timeout_o
);
  int hi_run;

  always_ff @(posedge clk) begin
    if (rst)                       hi_run <= 0;
    else if (pin_oe_o && pin_do_o) hi_run <= hi_run + 1;
    else                           hi_run <= 0;
  end

  a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  a_r6_high_needs_oe: assert property (@(posedge clk) disable iff (rst)
    pin_do_o |-> pin_oe_o);

  a_r6_pulse_one_tick: assert property (@(posedge clk) disable iff (rst)
    (pin_oe_o && pin_do_o) |-> (hi_run < TICK_DIV));

  a_r7_quiet_when_not_sending: assert property (@(posedge clk) disable iff (rst)
    (!busy_o || !dir_q) |=> !pin_oe_o);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r9_timeout_ends_busy: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!busy_o && $past(busy_o)));

  a_r9_no_double_strobe: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));
endmodule

bind owire_bit_xcvr owire_bit_xcvr_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .dir_q(dir_q),
  .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o), .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/owire_bit_xcvr_test.sv
module owire_bit_xcvr_test;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 128;
  localparam int NVEC       = 8;
  // {dir_tx, len16, data[15:0], expected[15:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 16'h00A5, 16'h00A5},
    {1'b0, 1'b0, 16'h003C, 16'h003C},
    {1'b0, 1'b0, 16'h0001, 16'h0001},
    {1'b0, 1'b1, 16'hBEEF, 16'hBEEF},
    {1'b1, 1'b0, 16'h005A, 16'h005A},
    {1'b1, 1'b1, 16'h8001, 16'h8001},
    {1'b1, 1'b0, 16'h12FF, 16'h00FF},
    {1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, dir_tx_i = 1'b0, len16_i = 1'b0;
  logic [15:0] tx_data_i = '0;
  logic pin_oe_o, pin_do_o, busy_o, done_o, timeout_o;
  logic [15:0] rx_data_o;
  logic host_low = 1'b0;
  logic line;

  int nchk = 0, nfail = 0;
  int done_cnt = 0, tout_cnt = 0;
  logic [15:0] rx_at_done = '0;
  logic busy_at_done = 1'b0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_comb line = host_low ? 1'b0 : (pin_oe_o ? pin_do_o : 1'b1);

  owire_bit_xcvr uut (
    .clk(clk), .rst(rst), .pin_i(line), .start_i(start_i), .dir_tx_i(dir_tx_i),
    .len16_i(len16_i), .tx_data_i(tx_data_i), .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o),
    .rx_data_o(rx_data_o), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        done_cnt++;
        rx_at_done = rx_data_o;
        busy_at_done = busy_o;
      end
      if (timeout_o) tout_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  // One host bit time: falling edge, hold low for a 0, read line at 10 target clocks.
  task automatic host_bit(input logic v, output logic rd, output int hi, output int oe_n);
    hi = 0; oe_n = 0; rd = 1'b1;
    for (int c = 0; c < BIT_CLKS; c++) begin
      @(negedge clk);
      if (c == 80) rd = line;
      if (pin_oe_o && pin_do_o) hi++;
      if (pin_oe_o) oe_n++;
      host_low = (c < (v ? 16 : 104));
    end
    host_low = 1'b0;
  endtask

  task automatic begin_xfer(input logic dtx, input logic l16, input logic [15:0] d);
    @(negedge clk);
    start_i = 1'b1; dir_tx_i = dtx; len16_i = l16; tx_data_i = d;
    @(negedge clk);
    start_i = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic run_bits(input logic dtx, input logic l16, input logic [15:0] d,
                          output logic [15:0] got, output int bad_drive);
    int n;
    logic rd, b;
    int hi, oe_n;
    n = l16 ? 16 : 8;
    got = '0; bad_drive = 0;
    for (int i = n - 1; i >= 0; i--) begin
      b = d[i];
      host_bit(dtx ? 1'b1 : b, rd, hi, oe_n);
      got = {got[14:0], rd};
      if (dtx) begin
        if (b && (hi != 8 || oe_n != 8)) bad_drive++;   // R6 one target clock high
        if (!b && (hi != 0 || oe_n != 104)) bad_drive++; // R5 13 target clocks low
      end else if (oe_n != 0) begin
        bad_drive++;                                     // R7 no drive in receive
      end
    end
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    report();
  end

  initial begin
    logic [15:0] got;
    int bad, d0, t0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pin_oe_o == 0, "R1 pin_oe_o after reset", pin_oe_o, 0);
    check(pin_do_o == 0, "R1 pin_do_o after reset", pin_do_o, 0);
    check(busy_o == 0, "R1 busy_o after reset", busy_o, 0);
    check(done_o == 0 && timeout_o == 0, "R1 strobes after reset", {done_o, timeout_o}, 0);

    // Vector table: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      d0 = done_cnt;
      begin_xfer(VEC[k][33], VEC[k][32], VEC[k][31:16]);
      check(busy_o == 1, "R2 busy after start", busy_o, 1);
      run_bits(VEC[k][33], VEC[k][32], VEC[k][31:16], got, bad);
      check(done_cnt == d0 + 1, "R8 single done strobe", done_cnt - d0, 1);
      check(busy_at_done == 0, "R8 busy low with done", busy_at_done, 0);
      check(bad == 0, "R5 R6 R7 pad drive per bit", bad, 0);
      if (VEC[k][33])
        check(got == VEC[k][15:0], "R4 R5 R6 host-read transmit data", got, VEC[k][15:0]);
      else
        check(rx_at_done == VEC[k][15:0], "R3 R4 R8 rx data at done", rx_at_done, VEC[k][15:0]);
    end

    // R2: start while busy is ignored
    begin_xfer(1'b1, 1'b0, 16'h00A5);
    @(negedge clk);
    start_i = 1'b1; dir_tx_i = 1'b0; len16_i = 1'b1; tx_data_i = 16'h0000;
    @(negedge clk);
    start_i = 1'b0;
    run_bits(1'b1, 1'b0, 16'h00A5, got, bad);
    check(got == 16'h00A5, "R2 second start ignored", got, 16'h00A5);
    check(bad == 0, "R2 transfer kept send direction", bad, 0);

    // R9: timeout after 512 silent target clocks
    d0 = done_cnt; t0 = tout_cnt;
    begin_xfer(1'b0, 1'b0, 16'h0000);
    begin
      logic rd; int hi, oe_n;
      host_bit(1'b1, rd, hi, oe_n);
      host_bit(1'b0, rd, hi, oe_n);
    end
    repeat (3700) @(negedge clk);
    check(tout_cnt == t0 && busy_o == 1, "R9 no early timeout", tout_cnt - t0, 0);
    repeat (500) @(negedge clk);
    check(tout_cnt == t0 + 1, "R9 timeout strobe", tout_cnt - t0, 1);
    check(busy_o == 0, "R9 busy cleared", busy_o, 0);
    check(done_cnt == d0, "R9 no done on abort", done_cnt - d0, 0);
    check(pin_oe_o == 0, "R9 R7 line released", pin_oe_o, 0);

    // R10: normal transfer after timeout
    d0 = done_cnt;
    begin_xfer(1'b0, 1'b0, 16'h0069);
    run_bits(1'b0, 1'b0, 16'h0069, got, bad);
    check(done_cnt == d0 + 1, "R10 done after recovery", done_cnt - d0, 1);
    check(rx_at_done == 16'h0069, "R10 data after recovery", rx_at_done, 16'h0069);
    report();
  end
endmodule